// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel buses, A and B, and can pass data in either direction. Each bus has a storage register that has its own capture clock. The A register samples bus A and the B register samples bus B. An active-low enable and a direction input decide which bus, if any, is driven. For each direction, a select picks whether the driven bus carries live data from the opposite bus or the value held in that bus's register.

Each bus is modelled with three vectors: an input, an output and an output enable. The pad can then be built outside the block as a plain tri-state buffer. The live path is combinational and the stored path adds no extra delay beyond the register. When the enable is high, both output enables drop. This is isolation. Both registers keep capturing on their clock edges during isolation, so data can be parked in either register while neither bus is driven.

The buses are level-driven and have no transfer handshake. Every input and output here is a plain level signal with no valid/ready pairing, and there is no back-pressure to describe.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On each rising edge of `cap_a_clk` with `rst` low, the A register takes the value on `a_in`.
- R2: On each rising edge of `cap_b_clk` with `rst` low, the B register takes the value on `b_in`.
- R3: When `rst` is high at a rising edge of a register's own capture clock, that register clears to zero.
- R4: `b_oe` is all ones when `en_n` is 0 and `dir_a2b` is 1. Otherwise it is all zeros.
- R5: `a_oe` is all ones when `en_n` is 0 and `dir_a2b` is 0. Otherwise it is all zeros.
- R6: `b_out` equals `a_in` when `sel_ab_stored` is 0 and equals the A register when it is 1. The path is combinational and has no register delay.
- R7: `a_out` equals `b_in` when `sel_ba_stored` is 0 and equals the B register when it is 1. The path is combinational and has no register delay.
- R8: While `en_n` is 1, neither output enable is asserted, and captures into both registers still take place on their clock edges.
- R9: `a_oe` and `b_oe` are never asserted together. Every path is non-inverting, bit for bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Synchronous active-high clear. It is sampled on each capture clock. |
| cap_a_clk | input | 1 | Rising edge loads the A register from bus A. |
| cap_b_clk | input | 1 | Rising edge loads the B register from bus B. |
| en_n | input | 1 | Active-low drive enable. When it is high, both buses are isolated. |
| dir_a2b | input | 1 | 1: bus B is driven from the A side. 0: bus A is driven from the B side. |
| sel_ab_stored | input | 1 | A-to-B source. 0 selects live `a_in`, 1 selects the A register. |
| sel_ba_stored | input | 1 | B-to-A source. 0 selects live `b_in`, 1 selects the B register. |
| a_in | input | 8 | Value currently on bus A. |
| a_out | output | 8 | Value offered to bus A. |
| a_oe | output | 8 | Per-bit output enable for bus A. |
| b_in | input | 8 | Value currently on bus B. |
| b_out | output | 8 | Value offered to bus B. |
| b_oe | output | 8 | Per-bit output enable for bus B. |

## Verification
All sixteen combinations of enable, direction and the two selects are applied with the registers holding values that differ from the live buses. This shows whether each output carries live or stored data and whether the right bus is enabled. Walking-one and alternating bit patterns separate a correct path from one that swaps, inverts or drops bits. Captures made while the block is isolated are read back later through the stored path. This shows that isolation gates the drivers and leaves the registers free to load. Resets applied on each clock alone show that each clear reaches only its own register.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;

  // Transfer direction as coded on dir_a2b.
  typedef enum logic {
    XFER_B_TO_A = 1'b0,
    XFER_A_TO_B = 1'b1
  } xfer_dir_e;

  // Source choice for a driven bus.
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } path_src_e;

  typedef struct packed {
    logic drive_a;
    logic drive_b;
  } drive_req_t;

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  // R1 and R2: a capture edge outside reset stores the bus value
  assert_capture_follows_R1_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q == $past(d)));

  // R3: reset at a capture edge clears the register
  assert_reset_clears_R3: assert property (@(posedge clk)
    rst |=> (q == '0));

endmodule

// File: rtl/xcvr_path_sel.sv
module xcvr_path_sel #(
  parameter int WIDTH = 8
) (
  input  logic             sel_stored,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] y
);
  import bus_xcvr_pkg::*;

  path_src_e src;

  always_comb begin
    src = path_src_e'(sel_stored);
    y   = (src == SRC_STORED) ? stored : live;
  end

endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl #(
  parameter int WIDTH = 8
) (
  input  logic             en_n,
  input  logic             dir_a2b,
  output logic [WIDTH-1:0] a_oe,
  output logic [WIDTH-1:0] b_oe
);
  import bus_xcvr_pkg::*;

  drive_req_t req;
  xfer_dir_e  dir;

  always_comb begin
    dir         = xfer_dir_e'(dir_a2b);
    req.drive_a = !en_n && (dir == XFER_B_TO_A);
    req.drive_b = !en_n && (dir == XFER_A_TO_B);
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_oe_fan
    assign a_oe[i] = req.drive_a;
    assign b_oe[i] = req.drive_b;
  end

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int WIDTH = 8
) (
  input  logic             rst,
  input  logic             cap_a_clk,
  input  logic             cap_b_clk,
  input  logic             en_n,
  input  logic             dir_a2b,
  input  logic             sel_ab_stored,
  input  logic             sel_ba_stored,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe
);

  logic [WIDTH-1:0] a_held;
  logic [WIDTH-1:0] b_held;

  xcvr_capture_reg #(.WIDTH(WIDTH)) u_a_store (
    .clk(cap_a_clk), .rst(rst), .d(a_in), .q(a_held));

  xcvr_capture_reg #(.WIDTH(WIDTH)) u_b_store (
    .clk(cap_b_clk), .rst(rst), .d(b_in), .q(b_held));

  xcvr_path_sel #(.WIDTH(WIDTH)) u_a2b_sel (
    .sel_stored(sel_ab_stored), .live(a_in), .stored(a_held), .y(b_out));

  xcvr_path_sel #(.WIDTH(WIDTH)) u_b2a_sel (
    .sel_stored(sel_ba_stored), .live(b_in), .stored(b_held), .y(a_out));

  xcvr_drive_ctl #(.WIDTH(WIDTH)) u_drive (
    .en_n(en_n), .dir_a2b(dir_a2b), .a_oe(a_oe), .b_oe(b_oe));

  always_comb begin
    // R9: the two buses are never driven at once
    assert_single_driver_R9: assert (!((a_oe[0] === 1'b1) && (b_oe[0] === 1'b1)));
    // R8: isolation removes every output enable
    if (en_n === 1'b1) begin
      assert_isolated_R8: assert ((a_oe === '0) && (b_oe === '0));
    end
  end

endmodule

// File: tb/test_bus_xcvr_reg.sv
module test_bus_xcvr_reg;

  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz reference for the watchdog

  logic         rst = 1'b1;
  logic         cap_a_clk = 1'b0, cap_b_clk = 1'b0;
  logic         en_n = 1'b1, dir_a2b = 1'b0;
  logic         sel_ab_stored = 1'b0, sel_ba_stored = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_a_reg = '0, exp_b_reg = '0;

  bus_xcvr_reg #(.WIDTH(W)) i_bus_xcvr_reg (
    .rst(rst), .cap_a_clk(cap_a_clk), .cap_b_clk(cap_b_clk),
    .en_n(en_n), .dir_a2b(dir_a2b),
    .sel_ab_stored(sel_ab_stored), .sel_ba_stored(sel_ba_stored),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_a();
    #1 cap_a_clk = 1'b1;
    if (!rst) exp_a_reg = a_in; else exp_a_reg = '0;
    #1 cap_a_clk = 1'b0;
    #1;
  endtask

  task automatic pulse_b();
    #1 cap_b_clk = 1'b1;
    if (!rst) exp_b_reg = b_in; else exp_b_reg = '0;
    #1 cap_b_clk = 1'b0;
    #1;
  endtask

  // Read both registers through the stored paths
  task automatic check_regs(input string req);
    sel_ab_stored = 1'b1; sel_ba_stored = 1'b1;
    #1;
    check({req, " A reg"}, b_out, exp_a_reg);
    check({req, " B reg"}, a_out, exp_b_reg);
  endtask

  task automatic test_reset();
    rst = 1'b1; a_in = 8'h5A; b_in = 8'hC3;
    pulse_a(); pulse_b();
    rst = 1'b0;
    check_regs("R3 reset");
  endtask

  task automatic test_reset_separate();
    a_in = 8'h11; b_in = 8'h22; pulse_a(); pulse_b();
    rst = 1'b1; pulse_a(); rst = 1'b0;
    check_regs("R3 reset A only");
    b_in = 8'h33; pulse_b(); a_in = 8'h44; pulse_a();
    rst = 1'b1; pulse_b(); rst = 1'b0;
    check_regs("R3 reset B only");
  endtask

  task automatic test_capture_patterns();
    for (int i = 0; i < W; i++) begin
      a_in = 8'(1 << i); b_in = ~8'(1 << i);
      pulse_a(); pulse_b();
      check_regs("R1 R2 walking capture");
    end
    a_in = 8'hAA; b_in = 8'h55; pulse_a();
    check_regs("R1 only A captured");
    b_in = 8'h0F; pulse_b();
    check_regs("R2 only B captured");
  endtask

  task automatic test_all_controls();
    a_in = 8'h3C; pulse_a(); b_in = 8'hE1; pulse_b();
    a_in = 8'h96; b_in = 8'h69;
    for (int c = 0; c < 16; c++) begin
      en_n = c[3]; dir_a2b = c[2]; sel_ab_stored = c[1]; sel_ba_stored = c[0];
      #1;
      check("R4 b_oe", b_oe, (!en_n && dir_a2b) ? '1 : '0);
      check("R5 a_oe", a_oe, (!en_n && !dir_a2b) ? '1 : '0);
      check("R6 b_out", b_out, sel_ab_stored ? exp_a_reg : a_in);
      check("R7 a_out", a_out, sel_ba_stored ? exp_b_reg : b_in);
      check("R9 exclusive", {7'd0, a_oe[0] & b_oe[0]}, '0);
    end
  endtask

  task automatic test_live_follow();
    en_n = 1'b0; sel_ab_stored = 1'b0; sel_ba_stored = 1'b0;
    dir_a2b = 1'b1;
    for (int i = 0; i < W; i++) begin
      a_in = 8'(1 << i); #1;
      check("R6 R9 live walking one", b_out, 8'(1 << i));
    end
    dir_a2b = 1'b0;
    b_in = 8'hA5; #1; check("R7 R9 live pattern", a_out, 8'hA5);
    b_in = 8'h5A; #1; check("R7 R9 live pattern", a_out, 8'h5A);
  endtask

  task automatic test_isolated_capture();
    en_n = 1'b1; dir_a2b = 1'b1;
    a_in = 8'hD2; b_in = 8'h4B;
    pulse_a(); pulse_b();
    check("R8 b_oe isolated", b_oe, '0);
    check("R8 a_oe isolated", a_oe, '0);
    a_in = 8'h00; b_in = 8'hFF;
    check_regs("R8 isolated capture");
    en_n = 1'b0; #1;
    check("R8 R6 stored after isolation", b_out, 8'hD2);
    check("R4 b_oe after isolation", b_oe, '1);
  endtask

  initial begin
    #1;
    test_reset();
    test_reset_separate();
    test_capture_patterns();
    test_all_controls();
    test_live_follow();
    test_isolated_capture();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule